// File: doc/BRIEF.md
# Multimode Register with Shared Status Output

An 8-bit clocked register whose behaviour on each rising clock edge is picked by a 3-bit operation code. It can add the A-side input to its own contents, count up, shift serially, capture either side's input bus, or keep its value. One control input has a different meaning in each operation: carry-in, serial data or count enable. One status output also changes meaning with the operation: adder carry, all-ones flag, serial data out or register parity.

The register value is presented on both side outputs at all times. Each side has an active-low output enable that only produces that side's drive-enable signal. The enables never reach the register. An asynchronous active-low master reset clears the register and holds the status output low, whatever the operation code is.

Top module: `mmreg_top`

## Requirements
- R1: While `rst_n` is low, the register (seen on `a_out` and `b_out`) is 0 and `stat_out` is 0. This holds at once, without waiting for a clock edge, and for every `sel` value.
- R2: With `sel`=3'b000, the register takes the low 8 bits of Q + `a_in` + `ctl_in` on the rising edge.
- R3: With `sel`=3'b001, the register takes the low 8 bits of Q + `a_in`, and `ctl_in` has no effect. `b_in` is never an addend in either add code.
- R4: With `sel` 3'b000 or 3'b001, `stat_out` is the combinational ninth bit of that same sum, formed from the current Q. It is therefore visible one clock before the matching sum is stored.
- R5: With `sel`=3'b010, the register increments on the edge when `ctl_in` is 1 and is unchanged when `ctl_in` is 0. Increments wrap from 8'hFF to 8'h00.
- R6: With `sel`=3'b011, the register increments (wrapping) on every edge, whatever `ctl_in` is.
- R7: With `sel` 3'b010 or 3'b011, `stat_out` is 1 exactly when the register is 8'hFF.
- R8: With `sel`=3'b100, the register shifts toward the MSB and `ctl_in` enters bit 0. `stat_out` shows bit 7 of the register.
- R9: With `sel`=3'b101 the register captures `a_in`, and with `sel`=3'b110 it captures `b_in`.
- R10: With `sel`=3'b111, the register keeps its value.
- R11: With `sel` 3'b101, 3'b110 or 3'b111, `stat_out` is 1 when the register holds an odd number of 1 bits.
- R12: `a_drive` equals NOT `a_oe_n` and `b_drive` equals NOT `b_oe_n`. Both `a_out` and `b_out` always equal the register. The enables do not change any register update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous master reset, active low |
| sel | input | 3 | Operation code |
| ctl_in | input | 1 | Carry-in, serial data or count enable, depending on the code |
| a_in | input | 8 | A-side input bus |
| b_in | input | 8 | B-side input bus |
| a_oe_n | input | 1 | A-side output enable, active low |
| b_oe_n | input | 1 | B-side output enable, active low |
| a_out | output | 8 | Register value toward the A side |
| b_out | output | 8 | Register value toward the B side |
| a_drive | output | 1 | A-side drive enable, active high |
| b_drive | output | 1 | B-side drive enable, active high |
| stat_out | output | 1 | Status: carry, all-ones flag, serial out or parity |

## Verification
`stat_out` depends combinationally on the current register value and the inputs. It is therefore due in the same cycle as the input change. The bench drives inputs on the falling edge and checks status 1 ns later, before the next rising edge, against a model computed from the pre-edge register. Register results are due one rising edge after the operation code is applied, and are sampled 1 ns after that edge. The master reset takes effect within the cycle it is asserted in: the bench pulls it low between edges and checks the cleared outputs before any edge arrives.

// File: rtl/mmreg_pkg.sv
package mmreg_pkg;

    typedef enum logic [2:0] {
        OP_ADD_CI  = 3'b000,
        OP_ADD     = 3'b001,
        OP_CNT_EN  = 3'b010,
        OP_CNT     = 3'b011,
        OP_SHIFT   = 3'b100,
        OP_LOAD_A  = 3'b101,
        OP_LOAD_B  = 3'b110,
        OP_HOLD    = 3'b111
    } op_e;

    typedef enum logic [1:0] {
        STK_CARRY,
        STK_ALLONE,
        STK_SERIAL,
        STK_PARITY
    } stat_kind_e;

    // Which meaning the status pin takes for a given operation
    function automatic stat_kind_e stat_kind(op_e op);
        case (op)
            OP_ADD_CI, OP_ADD:  return STK_CARRY;
            OP_CNT_EN, OP_CNT:  return STK_ALLONE;
            OP_SHIFT:           return STK_SERIAL;
            default:            return STK_PARITY;
        endcase
    endfunction

    function automatic logic uses_carry_in(op_e op);
        return op == OP_ADD_CI;
    endfunction

endpackage

// File: rtl/mmreg_next.sv
module mmreg_next
    import mmreg_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e           op,
    input  logic          ctl,
    input  logic [W-1:0]  q,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  nxt,
    output logic          carry
);
    localparam int WS = W + 1;

    logic [WS-1:0] sum;
    logic [W-1:0]  inc;

    always_comb begin
        sum = {1'b0, q} + {1'b0, a}
            + {{W{1'b0}}, (uses_carry_in(op) & ctl)};
        inc = q + {{(W-1){1'b0}}, 1'b1};
    end

    assign carry = sum[W];

    always_comb begin
        case (op)
            OP_ADD_CI, OP_ADD: nxt = sum[W-1:0];
            OP_CNT_EN:         nxt = ctl ? inc : q;
            OP_CNT:            nxt = inc;
            OP_SHIFT:          nxt = {q[W-2:0], ctl};
            OP_LOAD_A:         nxt = a;
            OP_LOAD_B:         nxt = b;
            default:           nxt = q;
        endcase
    end

endmodule

// File: rtl/mmreg_status.sv
module mmreg_status
    import mmreg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          rst_n,
    input  op_e           op,
    input  logic [W-1:0]  q,
    input  logic          carry,
    output logic          stat
);
    logic pick;

    always_comb begin
        case (stat_kind(op))
            STK_CARRY:  pick = carry;
            STK_ALLONE: pick = &q;
            STK_SERIAL: pick = q[W-1];
            default:    pick = ^q;
        endcase
    end

    // reset holds status low even if the adder path would give a carry
    assign stat = rst_n & pick;

endmodule

// File: rtl/mmreg_top.sv
module mmreg_top
    import mmreg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    sel,
    input  logic          ctl_in,
    input  logic [W-1:0]  a_in,
    input  logic [W-1:0]  b_in,
    input  logic          a_oe_n,
    input  logic          b_oe_n,
    output logic [W-1:0]  a_out,
    output logic [W-1:0]  b_out,
    output logic          a_drive,
    output logic          b_drive,
    output logic          stat_out
);
    localparam logic [W-1:0] ALL_ONE = {W{1'b1}};

    op_e          op;
    logic [W-1:0] q_r;
    logic [W-1:0] q_nxt;
    logic         add_carry;

    assign op = op_e'(sel);

    mmreg_next #(.W(W)) u_next (
        .op    (op),
        .ctl   (ctl_in),
        .q     (q_r),
        .a     (a_in),
        .b     (b_in),
        .nxt   (q_nxt),
        .carry (add_carry)
    );

    mmreg_status #(.W(W)) u_stat (
        .rst_n (rst_n),
        .op    (op),
        .q     (q_r),
        .carry (add_carry),
        .stat  (stat_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
    end

    assign a_out   = q_r;
    assign b_out   = q_r;
    assign a_drive = ~a_oe_n;
    assign b_drive = ~b_oe_n;

    // ---------------- assertions ----------------
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (q_r == '0 && !stat_out));

    assert_add_ci_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD_CI) |=> q_r == W'($past(q_r) + $past(a_in) + W'($past(ctl_in))));

    assert_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD) |=> q_r == W'($past(q_r) + $past(a_in)));

    assert_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD) |-> stat_out == (({1'b0, q_r} + {1'b0, a_in}) > {1'b0, ALL_ONE}));

    assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CNT_EN && !ctl_in) |=> $stable(q_r));

    assert_cnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CNT) |=> q_r == W'($past(q_r) + 1'b1));

    assert_allone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CNT || op == OP_CNT_EN) |-> stat_out == (q_r == ALL_ONE));

    assert_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT) |=> (q_r[0] == $past(ctl_in) && q_r[W-1:1] == $past(q_r[W-2:0])));

    assert_load_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD_B) |=> q_r == $past(b_in));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(q_r));

    assert_parity_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |-> stat_out == $countones(q_r) % 2);

    assert_drive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drive != a_oe_n) && (b_drive != b_oe_n) && (a_out == b_out));

endmodule

// File: tb/sim_mmreg_top.sv
module sim_mmreg_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [2:0]   sel;
    logic         ctl_in;
    logic [W-1:0] a_in, b_in;
    logic         a_oe_n, b_oe_n;
    logic [W-1:0] a_out, b_out;
    logic         a_drive, b_drive, stat_out;

    int n_chk  = 0;
    int n_fail = 0;
    logic [W-1:0] q_ref;

    always #4 clk = ~clk;

    mmreg_top #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .ctl_in(ctl_in),
        .a_in(a_in), .b_in(b_in), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n),
        .a_out(a_out), .b_out(b_out), .a_drive(a_drive), .b_drive(b_drive),
        .stat_out(stat_out)
    );

    // vector fields: {sel[19:17], ctl[16], a[15:8], b[7:0]}
    localparam logic [19:0] VEC [0:17] = '{
        {3'b101, 1'b0, 8'h5A, 8'h00},
        {3'b111, 1'b1, 8'h00, 8'h00},
        {3'b110, 1'b1, 8'h11, 8'hC3},
        {3'b000, 1'b1, 8'h30, 8'hFF},
        {3'b001, 1'b1, 8'hF0, 8'h0F},
        {3'b001, 1'b0, 8'h22, 8'h00},
        {3'b010, 1'b1, 8'h00, 8'h00},
        {3'b010, 1'b0, 8'hFF, 8'hFF},
        {3'b011, 1'b0, 8'h00, 8'h00},
        {3'b100, 1'b1, 8'h00, 8'h00},
        {3'b100, 1'b0, 8'hAA, 8'h00},
        {3'b100, 1'b1, 8'h00, 8'h00},
        {3'b101, 1'b0, 8'hFE, 8'h00},
        {3'b011, 1'b1, 8'h00, 8'h00},
        {3'b011, 1'b0, 8'h00, 8'h00},
        {3'b110, 1'b0, 8'h00, 8'h80},
        {3'b000, 1'b1, 8'h7F, 8'h00},
        {3'b000, 1'b0, 8'hFF, 8'h00}
    };

    function automatic logic ref_stat(logic [2:0] s, logic c, logic [W-1:0] q, logic [W-1:0] a);
        logic [W:0] t;
        t = {1'b0, q} + {1'b0, a} + ((s == 3'b000) ? {{W{1'b0}}, c} : '0);
        case (s)
            3'b000, 3'b001: return t[W];
            3'b010, 3'b011: return q == {W{1'b1}};
            3'b100:         return q[W-1];
            default:        return ^q;
        endcase
    endfunction

    function automatic logic [W-1:0] ref_next(logic [2:0] s, logic c, logic [W-1:0] q,
                                              logic [W-1:0] a, logic [W-1:0] b);
        case (s)
            3'b000: return q + a + {{(W-1){1'b0}}, c};
            3'b001: return q + a;
            3'b010: return c ? q + 1'b1 : q;
            3'b011: return q + 1'b1;
            3'b100: return {q[W-2:0], c};
            3'b101: return a;
            3'b110: return b;
            default: return q;
        endcase
    endfunction

    function automatic string q_tag(logic [2:0] s);
        case (s)
            3'b000: return "R2";
            3'b001: return "R3";
            3'b010: return "R5";
            3'b011: return "R6";
            3'b100: return "R8";
            3'b111: return "R10";
            default: return "R9";
        endcase
    endfunction

    function automatic string s_tag(logic [2:0] s);
        case (s)
            3'b000, 3'b001: return "R4";
            3'b010, 3'b011: return "R7";
            3'b100:         return "R8";
            default:        return "R11";
        endcase
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // apply one operation: status checked before the edge, register after it
    task automatic step(logic [2:0] s, logic c, logic [W-1:0] a, logic [W-1:0] b);
        @(negedge clk);
        sel = s; ctl_in = c; a_in = a; b_in = b;
        #1;
        check(s_tag(s), {7'b0, stat_out}, {7'b0, ref_stat(s, c, q_ref, a)});
        q_ref = ref_next(s, c, q_ref, a, b);
        @(posedge clk);
        #1;
        check(q_tag(s), a_out, q_ref);
        check("R12", b_out, q_ref);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sel = 3'b111; ctl_in = 1'b0; a_in = '0; b_in = '0;
        a_oe_n = 1'b0; b_oe_n = 1'b0; q_ref = '0;
        repeat (2) @(posedge clk);
        #1;
        check("R1", a_out, 8'h00);
        check("R1", {7'b0, stat_out}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < 18; i++)
            step(VEC[i][19:17], VEC[i][16], VEC[i][15:8], VEC[i][7:0]);

        // R5/R6/R7: all-ones flag and wrap
        step(3'b101, 1'b0, 8'hFF, 8'h00);
        step(3'b010, 1'b0, 8'h00, 8'h00);
        step(3'b010, 1'b1, 8'h00, 8'h00);
        check("R5", a_out, 8'h00);

        // R4: carry seen before the sum is stored
        step(3'b101, 1'b0, 8'h01, 8'h00);
        @(negedge clk);
        sel = 3'b000; ctl_in = 1'b1; a_in = 8'hFE;
        #1;
        check("R4", {7'b0, stat_out}, 8'h01);
        check("R4", a_out, 8'h01);
        @(posedge clk); #1;
        check("R2", a_out, 8'h00);
        q_ref = 8'h00;

        // R12: enables produce drive signals only
        @(negedge clk);
        a_oe_n = 1'b1; b_oe_n = 1'b0; sel = 3'b111;
        #1;
        check("R12", {7'b0, a_drive}, 8'h00);
        check("R12", {7'b0, b_drive}, 8'h01);
        step(3'b101, 1'b0, 8'h3C, 8'h00);
        @(negedge clk);
        a_oe_n = 1'b0; b_oe_n = 1'b1;
        #1;
        check("R12", {7'b0, a_drive}, 8'h01);
        check("R12", {7'b0, b_drive}, 8'h00);
        step(3'b110, 1'b0, 8'h00, 8'h81);

        // R1: asynchronous reset mid-cycle, adder would give a carry
        step(3'b101, 1'b0, 8'h77, 8'h00);
        @(negedge clk);
        sel = 3'b000; ctl_in = 1'b1; a_in = 8'hFF;
        #1;
        rst_n = 1'b0;
        #1;
        check("R1", a_out, 8'h00);
        check("R1", {7'b0, stat_out}, 8'h00);
        @(posedge clk); #1;
        check("R1", a_out, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        q_ref = 8'h00;
        #1;
        check("R4", {7'b0, stat_out}, 8'h01);
        @(posedge clk); #1;
        check("R2", a_out, 8'h00);

        step(3'b111, 1'b0, 8'h00, 8'h00);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule